// File: doc/BRIEF.md
# Variable-Length Halfword Instruction Decoder

This block is the decode stage for a 32-bit machine with sixteen general registers whose instructions are built from 16-bit halfwords. Each accepted halfword is split into an instruction form, an operation code, register indices and an immediate. The block also reports the byte length of the instruction, whether it is illegal, and side attributes for later stages: a trap marker, shift-amount masking, memory access direction and size, and a special-register index.

Some operations are followed by a 32-bit extension word. For these the decoder drops its halfword ready and waits for the word on a separate port. It then presents the word as the immediate and reports a length of 6 bytes. All other instructions are 2 bytes long and are presented one cycle after acceptance.

The outputs are registered. `dec_valid` pulses for exactly one cycle per decoded instruction, and the fields hold their values until the next decode.

Top module: `halfword_decoder`

## Requirements
- R1: After reset `dec_valid` is 0 and `hw_ready` is 1.
- R2: The form is taken from halfword bits 15:14. A 0 in bit 15 gives form 1. `10` gives form 2. `11` gives form 3. `dec_form` encodes these as 2'd1, 2'd2 and 2'd3.
- R3: Form 1 fields: `dec_op` = bits 15:8, `dec_ra` = bits 7:4, `dec_rb` = bits 3:0.
- R4: Form 2 fields: `dec_op` = bits 13:12 (0 increment, 1 decrement, 2 read special register, 3 write special register), `dec_ra` = bits 11:8, `dec_rb` = 0, and `dec_imm` = bits 7:0 zero-extended. For operations 2 and 3, `dec_sreg` = bits 7:0; otherwise it is 0.
- R5: Form 3 (conditional branch) fields: `dec_op` = bits 13:10, and `dec_imm` = bits 9:0 sign-extended and multiplied by two. A condition code above 9 is flagged by `dec_illegal`.
- R6: Form 1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39 give `dec_len` = 6 and `dec_imm` = the extension word. Every other instruction gives `dec_len` = 2.
- R7: A form 1 opcode is legal in the ranges 0x00 to 0x0E and 0x19 to 0x39. Any other form 1 opcode sets `dec_illegal`, has length 2, and clears trap, shift and memory flags.
- R8: `dec_shift` is 1 only for opcodes 0x27, 0x28 and 0x2D. It means only the low 5 bits of register B give the shift amount.
- R9: `dec_trap` is 1 for opcodes 0x30 and 0x35. For 0x30 (software interrupt), `dec_sreg` = 3 and `dec_imm` = the extension word.
- R10: `dec_size` gives the memory access size: 0 none, 1 byte, 2 halfword, 3 word.
  - Word loads (size 3): 0x08, 0x0A, 0x0C.
  - Byte loads (size 1): 0x1C, 0x1D, 0x36.
  - Halfword loads (size 2): 0x21, 0x22, 0x38.
  - Word stores (size 3): 0x09, 0x0B, 0x0D.
  - Byte stores (size 1): 0x1E, 0x1F, 0x37.
  - Halfword stores (size 2): 0x23, 0x24, 0x39.
  - `dec_load` marks loads and `dec_store` marks stores.
- R11: Timing of the handshake:
  - A halfword is accepted when `hw_valid` and `hw_ready` are both high.
  - For a 2-byte instruction, `dec_valid` is high in the next cycle.
  - For a 6-byte instruction, `hw_ready` is low from the next cycle until the extension word is taken with `ext_valid`. `dec_valid` is high the cycle after that.
  - `ext_valid` has no effect when no extension word is awaited.
  - `hw_valid` has no effect while `hw_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Instruction halfword present |
| hw_data | input | 16 | Instruction halfword |
| hw_ready | output | 1 | Decoder can take a halfword |
| ext_valid | input | 1 | Extension word present |
| ext_data | input | 32 | Extension word |
| dec_valid | output | 1 | Decoded fields valid (one-cycle pulse) |
| dec_form | output | 2 | Instruction form 1, 2 or 3 |
| dec_op | output | 8 | Operation / opcode / condition |
| dec_ra | output | 4 | Register A index |
| dec_rb | output | 4 | Register B index |
| dec_imm | output | 32 | Immediate or extension word |
| dec_len | output | 3 | Instruction length in bytes |
| dec_illegal | output | 1 | Bad instruction |
| dec_trap | output | 1 | Trap-raising instruction |
| dec_shift | output | 1 | Shift amount masked to 5 bits |
| dec_load | output | 1 | Memory load |
| dec_store | output | 1 | Memory store |
| dec_size | output | 2 | Access size code |
| dec_sreg | output | 8 | Special register index |

## Verification
A wrong phase state shows at the ports at once. A stuck wait phase keeps `hw_ready` low. A missed wait makes a 6-byte instruction appear one cycle after its halfword, with a zero immediate instead of the extension word. A fault in the opcode attribute tables shows on the same `dec_valid` pulse as a wrong length, legality, trap, shift or size field. For that reason the directed tests place legal and illegal opcodes on both sides of every range edge. A branch offset fault shows as a wrong sign or scale in `dec_imm` on the first branch with a negative offset.

// File: rtl/hwdec_pkg.sv
package hwdec_pkg;
    localparam int HW_W        = 16;
    localparam int WORD_W      = 32;
    localparam int RIDX_W      = 4;
    localparam int OP_W        = 8;
    localparam int LEN_W       = 3;
    localparam int SREG_W      = 8;
    localparam int BR_OFF_W    = 10;
    localparam int BR_COND_W   = 4;
    localparam int BR_COND_MAX = 9;
    localparam int F2_IMM_W    = 8;
    localparam logic [LEN_W-1:0]  SHORT_LEN = LEN_W'(2);
    localparam logic [LEN_W-1:0]  LONG_LEN  = LEN_W'(6);
    localparam logic [SREG_W-1:0] SWI_SREG  = SREG_W'(3);

    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_ONE   = 2'd1,
        FORM_TWO   = 2'd2,
        FORM_THREE = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } msize_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EXT  = 1'b1
    } phase_e;

    typedef struct packed {
        form_e               form;
        logic [OP_W-1:0]     op;
        logic [RIDX_W-1:0]   ra;
        logic [RIDX_W-1:0]   rb;
        logic [WORD_W-1:0]   imm;
        logic [LEN_W-1:0]    len;
        logic                illegal;
        logic                trap;
        logic                shift;
        logic                load;
        logic                store;
        msize_e              size;
        logic [SREG_W-1:0]   sreg;
    } dec_t;
endpackage

// File: rtl/hwdec_opinfo.sv
module hwdec_opinfo
    import hwdec_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output logic            legal,
    output logic            has_ext,
    output logic            trap,
    output logic            is_swi,
    output logic            shift,
    output logic            load,
    output logic            store,
    output msize_e          size
);
    always_comb begin
        legal   = (op <= OP_W'(8'h0E)) ||
                  ((op >= OP_W'(8'h19)) && (op <= OP_W'(8'h39)));
        has_ext = op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
                             8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
                             8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39};
        is_swi  = (op == OP_W'(8'h30));
        trap    = is_swi || (op == OP_W'(8'h35));
        shift   = op inside {8'h27, 8'h28, 8'h2D};
        load    = op inside {8'h08, 8'h0A, 8'h0C, 8'h1C, 8'h1D, 8'h36,
                             8'h21, 8'h22, 8'h38};
        store   = op inside {8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F, 8'h37,
                             8'h23, 8'h24, 8'h39};
        if (op inside {8'h08, 8'h0A, 8'h0C, 8'h09, 8'h0B, 8'h0D}) begin
            size = SZ_WORD;
        end else if (op inside {8'h1C, 8'h1D, 8'h36, 8'h1E, 8'h1F, 8'h37}) begin
            size = SZ_BYTE;
        end else if (op inside {8'h21, 8'h22, 8'h38, 8'h23, 8'h24, 8'h39}) begin
            size = SZ_HALF;
        end else begin
            size = SZ_NONE;
        end
    end
endmodule

// File: rtl/hwdec_split.sv
module hwdec_split
    import hwdec_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    output dec_t            fields,
    output logic            need_ext
);
    logic   o_legal, o_ext, o_trap, o_swi, o_shift, o_load, o_store;
    msize_e o_size;

    hwdec_opinfo u_opinfo (
        .op      (hw[HW_W-1 -: OP_W]),
        .legal   (o_legal),
        .has_ext (o_ext),
        .trap    (o_trap),
        .is_swi  (o_swi),
        .shift   (o_shift),
        .load    (o_load),
        .store   (o_store),
        .size    (o_size)
    );

    logic [BR_COND_W-1:0] br_cond;
    logic [WORD_W-1:0]    br_off;

    assign br_cond = hw[BR_OFF_W +: BR_COND_W];
    assign br_off  = {{(WORD_W-BR_OFF_W-1){hw[BR_OFF_W-1]}}, hw[BR_OFF_W-1:0], 1'b0};

    always_comb begin
        fields   = '0;
        need_ext = 1'b0;
        if (!hw[15]) begin
            fields.form    = FORM_ONE;
            fields.op      = hw[15:8];
            fields.ra      = hw[7:4];
            fields.rb      = hw[3:0];
            fields.illegal = !o_legal;
            if (o_legal) begin
                need_ext     = o_ext;
                fields.len   = o_ext ? LONG_LEN : SHORT_LEN;
                fields.trap  = o_trap;
                fields.shift = o_shift;
                fields.load  = o_load;
                fields.store = o_store;
                fields.size  = o_size;
                fields.sreg  = o_swi ? SWI_SREG : '0;
            end else begin
                fields.len   = SHORT_LEN;
            end
        end else if (!hw[14]) begin
            fields.form = FORM_TWO;
            fields.op   = OP_W'(hw[13:12]);
            fields.ra   = hw[11:8];
            fields.imm  = WORD_W'(hw[F2_IMM_W-1:0]);
            fields.len  = SHORT_LEN;
            fields.sreg = hw[13] ? SREG_W'(hw[F2_IMM_W-1:0]) : '0;
        end else begin
            fields.form    = FORM_THREE;
            fields.op      = OP_W'(br_cond);
            fields.imm     = br_off;
            fields.len     = SHORT_LEN;
            fields.illegal = (br_cond > BR_COND_W'(BR_COND_MAX));
        end
    end
endmodule

// File: rtl/halfword_decoder.sv
module halfword_decoder
    import hwdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_valid,
    input  logic [HW_W-1:0]     hw_data,
    output logic                hw_ready,
    input  logic                ext_valid,
    input  logic [WORD_W-1:0]   ext_data,
    output logic                dec_valid,
    output logic [1:0]          dec_form,
    output logic [OP_W-1:0]     dec_op,
    output logic [RIDX_W-1:0]   dec_ra,
    output logic [RIDX_W-1:0]   dec_rb,
    output logic [WORD_W-1:0]   dec_imm,
    output logic [LEN_W-1:0]    dec_len,
    output logic                dec_illegal,
    output logic                dec_trap,
    output logic                dec_shift,
    output logic                dec_load,
    output logic                dec_store,
    output logic [1:0]          dec_size,
    output logic [SREG_W-1:0]   dec_sreg
);
    typedef struct packed {
        phase_e phase;
        logic   vld;
        dec_t   dec;
    } st_t;

    st_t  st_d, st_q;
    dec_t fresh;
    logic fresh_ext;

    hwdec_split u_split (
        .hw       (hw_data),
        .fields   (fresh),
        .need_ext (fresh_ext)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (hw_valid) begin
                    st_d.dec = fresh;
                    if (fresh_ext) begin
                        st_d.phase = PH_EXT;
                    end else begin
                        st_d.vld = 1'b1;
                    end
                end
            end
            PH_EXT: begin
                if (ext_valid) begin
                    st_d.dec.imm = ext_data;
                    st_d.vld     = 1'b1;
                    st_d.phase   = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hw_ready    = (st_q.phase == PH_IDLE);
    assign dec_valid   = st_q.vld;
    assign dec_form    = st_q.dec.form;
    assign dec_op      = st_q.dec.op;
    assign dec_ra      = st_q.dec.ra;
    assign dec_rb      = st_q.dec.rb;
    assign dec_imm     = st_q.dec.imm;
    assign dec_len     = st_q.dec.len;
    assign dec_illegal = st_q.dec.illegal;
    assign dec_trap    = st_q.dec.trap;
    assign dec_shift   = st_q.dec.shift;
    assign dec_load    = st_q.dec.load;
    assign dec_store   = st_q.dec.store;
    assign dec_size    = st_q.dec.size;
    assign dec_sreg    = st_q.dec.sreg;
endmodule

// File: rtl/hwdec_checker.sv
module hwdec_checker
    import hwdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hw_valid,
    input logic              hw_ready,
    input logic              ext_valid,
    input logic              dec_valid,
    input logic [1:0]        dec_form,
    input logic [WORD_W-1:0] dec_imm,
    input logic [LEN_W-1:0]  dec_len,
    input logic              dec_illegal,
    input logic              dec_trap,
    input logic              dec_load,
    input logic              dec_store,
    input logic [1:0]        dec_size
);
    p_len_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_len == SHORT_LEN || dec_len == LONG_LEN));

    p_long_waits_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_len == LONG_LEN) |-> $past(ext_valid && !hw_ready));

    p_short_follows_hw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_len == SHORT_LEN) |-> $past(hw_valid && hw_ready));

    p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hw_ready) |-> $past(hw_valid));

    p_trap_form_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_trap) |-> (dec_form == 2'd1 && !dec_illegal));

    p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_illegal) |-> (dec_len == SHORT_LEN && !dec_trap && dec_size == 2'd0));

    p_form_two_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_form == 2'd2) |-> (dec_imm[WORD_W-1:F2_IMM_W] == '0 && dec_len == SHORT_LEN));

    p_mem_direction_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_size != 2'd0) |-> (dec_load != dec_store));
endmodule

bind halfword_decoder hwdec_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_valid    (hw_valid),
    .hw_ready    (hw_ready),
    .ext_valid   (ext_valid),
    .dec_valid   (dec_valid),
    .dec_form    (dec_form),
    .dec_imm     (dec_imm),
    .dec_len     (dec_len),
    .dec_illegal (dec_illegal),
    .dec_trap    (dec_trap),
    .dec_load    (dec_load),
    .dec_store   (dec_store),
    .dec_size    (dec_size)
);

// File: tb/halfword_decoder_test.sv
`timescale 1ns/1ps
module halfword_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_valid = 1'b0;
    logic [15:0] hw_data = '0;
    logic        hw_ready;
    logic        ext_valid = 1'b0;
    logic [31:0] ext_data = '0;
    logic        dec_valid;
    logic [1:0]  dec_form;
    logic [7:0]  dec_op;
    logic [3:0]  dec_ra, dec_rb;
    logic [31:0] dec_imm;
    logic [2:0]  dec_len;
    logic        dec_illegal, dec_trap, dec_shift, dec_load, dec_store;
    logic [1:0]  dec_size;
    logic [7:0]  dec_sreg;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    halfword_decoder uut (
        .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
        .hw_ready(hw_ready), .ext_valid(ext_valid), .ext_data(ext_data),
        .dec_valid(dec_valid), .dec_form(dec_form), .dec_op(dec_op),
        .dec_ra(dec_ra), .dec_rb(dec_rb), .dec_imm(dec_imm), .dec_len(dec_len),
        .dec_illegal(dec_illegal), .dec_trap(dec_trap), .dec_shift(dec_shift),
        .dec_load(dec_load), .dec_store(dec_store), .dec_size(dec_size),
        .dec_sreg(dec_sreg)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] hw);
        @(negedge clk);
        hw_valid = 1'b1;
        hw_data  = hw;
        @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic supply_ext(input logic [31:0] w);
        ext_valid = 1'b1;
        ext_data  = w;
        @(negedge clk);
        ext_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "dec_valid", 32'(dec_valid), 32'd0);
        chk("R1", "hw_ready", 32'(hw_ready), 32'd1);
    endtask

    task automatic t_form_one_short;
        issue(16'h053A);
        chk("R11", "valid", 32'(dec_valid), 32'd1);
        chk("R2", "form", 32'(dec_form), 32'd1);
        chk("R3", "op", 32'(dec_op), 32'h05);
        chk("R3", "ra", 32'(dec_ra), 32'h3);
        chk("R3", "rb", 32'(dec_rb), 32'hA);
        chk("R6", "len", 32'(dec_len), 32'd2);
        chk("R7", "illegal", 32'(dec_illegal), 32'd0);
        @(negedge clk);
        chk("R11", "pulse ends", 32'(dec_valid), 32'd0);
    endtask

    task automatic t_form_one_ext;
        issue(16'h0C47);
        chk("R11", "wait valid", 32'(dec_valid), 32'd0);
        chk("R11", "wait ready", 32'(hw_ready), 32'd0);
        hw_valid = 1'b1;
        hw_data  = 16'h0512;
        @(negedge clk);
        @(negedge clk);
        hw_valid = 1'b0;
        chk("R11", "still waiting", 32'(dec_valid), 32'd0);
        supply_ext(32'hDEADBEEF);
        chk("R11", "ext valid", 32'(dec_valid), 32'd1);
        chk("R11", "op kept", 32'(dec_op), 32'h0C);
        chk("R6", "imm", dec_imm, 32'hDEADBEEF);
        chk("R6", "len", 32'(dec_len), 32'd6);
        chk("R10", "size", 32'(dec_size), 32'd3);
        chk("R10", "load", 32'(dec_load), 32'd1);
        chk("R10", "store", 32'(dec_store), 32'd0);
        chk("R11", "ready back", 32'(hw_ready), 32'd1);
    endtask

    task automatic t_form_two;
        issue(16'h9A7F);
        chk("R2", "form", 32'(dec_form), 32'd2);
        chk("R4", "op", 32'(dec_op), 32'd1);
        chk("R4", "ra", 32'(dec_ra), 32'hA);
        chk("R4", "imm", dec_imm, 32'h7F);
        chk("R4", "sreg", 32'(dec_sreg), 32'd0);
        issue(16'hA3C5);
        chk("R4", "op gsr", 32'(dec_op), 32'd2);
        chk("R4", "ra gsr", 32'(dec_ra), 32'h3);
        chk("R4", "sreg gsr", 32'(dec_sreg), 32'hC5);
        chk("R6", "len", 32'(dec_len), 32'd2);
    endtask

    task automatic t_form_three;
        issue(16'hC5FF);
        chk("R2", "form", 32'(dec_form), 32'd3);
        chk("R5", "cond", 32'(dec_op), 32'd1);
        chk("R5", "pos off", dec_imm, 32'h000003FE);
        issue(16'hC600);
        chk("R5", "neg off", dec_imm, 32'hFFFFFC00);
        issue(16'hE400);
        chk("R5", "cond 9 legal", 32'(dec_illegal), 32'd0);
        issue(16'hE800);
        chk("R5", "cond 10 illegal", 32'(dec_illegal), 32'd1);
    endtask

    task automatic t_legality;
        issue(16'h0F00);
        chk("R7", "0x0F illegal", 32'(dec_illegal), 32'd1);
        chk("R7", "0x0F len", 32'(dec_len), 32'd2);
        issue(16'h1800);
        chk("R7", "0x18 illegal", 32'(dec_illegal), 32'd1);
        issue(16'h1912);
        chk("R7", "0x19 legal", 32'(dec_illegal), 32'd0);
        chk("R7", "0x19 valid", 32'(dec_valid), 32'd1);
        issue(16'h3A00);
        chk("R7", "0x3A illegal", 32'(dec_illegal), 32'd1);
        chk("R7", "0x3A size", 32'(dec_size), 32'd0);
        issue(16'h0E12);
        chk("R7", "0x0E legal", 32'(dec_illegal), 32'd0);
        issue(16'h3900);
        chk("R6", "0x39 waits", 32'(hw_ready), 32'd0);
        supply_ext(32'h00000010);
        chk("R6", "0x39 len", 32'(dec_len), 32'd6);
        chk("R10", "0x39 size", 32'(dec_size), 32'd2);
        chk("R10", "0x39 store", 32'(dec_store), 32'd1);
    endtask

    task automatic t_shift;
        issue(16'h2712);
        chk("R8", "0x27", 32'(dec_shift), 32'd1);
        issue(16'h2912);
        chk("R8", "0x29", 32'(dec_shift), 32'd0);
        issue(16'h2D00);
        chk("R8", "0x2D", 32'(dec_shift), 32'd1);
        issue(16'h2800);
        chk("R8", "0x28", 32'(dec_shift), 32'd1);
    endtask

    task automatic t_trap;
        issue(16'h3500);
        chk("R9", "brk trap", 32'(dec_trap), 32'd1);
        chk("R9", "brk len", 32'(dec_len), 32'd2);
        issue(16'h3000);
        chk("R9", "swi waits", 32'(dec_valid), 32'd0);
        supply_ext(32'h00001234);
        chk("R9", "swi trap", 32'(dec_trap), 32'd1);
        chk("R9", "swi sreg", 32'(dec_sreg), 32'd3);
        chk("R9", "swi code", dec_imm, 32'h00001234);
        issue(16'h3100);
        chk("R9", "div no trap", 32'(dec_trap), 32'd0);
    endtask

    task automatic t_mem;
        issue(16'h1C12);
        chk("R10", "ld.b size", 32'(dec_size), 32'd1);
        chk("R10", "ld.b load", 32'(dec_load), 32'd1);
        issue(16'h2334);
        chk("R10", "st.s size", 32'(dec_size), 32'd2);
        chk("R10", "st.s store", 32'(dec_store), 32'd1);
        chk("R10", "st.s load", 32'(dec_load), 32'd0);
        issue(16'h1F50);
        supply_ext(32'h00008000);
        chk("R10", "sta.b size", 32'(dec_size), 32'd1);
        chk("R10", "sta.b store", 32'(dec_store), 32'd1);
        issue(16'h0512);
        chk("R10", "add no mem", 32'(dec_size), 32'd0);
    endtask

    task automatic t_stray_ext;
        @(negedge clk);
        ext_valid = 1'b1;
        ext_data  = 32'hFFFFFFFF;
        @(negedge clk);
        ext_valid = 1'b0;
        chk("R11", "stray ext valid", 32'(dec_valid), 32'd0);
        chk("R11", "stray ext ready", 32'(hw_ready), 32'd1);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        hw_valid = 1'b1;
        hw_data  = 16'h2B45;
        @(negedge clk);
        hw_data  = 16'h2E67;
        chk("R11", "first valid", 32'(dec_valid), 32'd1);
        chk("R3", "first op", 32'(dec_op), 32'h2B);
        @(negedge clk);
        hw_valid = 1'b0;
        chk("R11", "second valid", 32'(dec_valid), 32'd1);
        chk("R3", "second op", 32'(dec_op), 32'h2E);
        chk("R3", "second ra", 32'(dec_ra), 32'h6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_form_one_short();
        t_form_one_ext();
        t_form_two();
        t_form_three();
        t_legality();
        t_shift();
        t_trap();
        t_mem();
        t_stray_ext();
        t_back_to_back();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule